// File: doc/BRIEF.md
# Dual-Source Bus Ready Synchronizer

This block merges the transfer-complete indications of several bus-ready sources into one registered ready signal for the processor. Each source has an active-low enable. A source's ready input counts only while its own enable is asserted. The qualified sources are combined with an OR. The result is then brought into the processor clock domain.

A static strap input selects the synchronization depth. Two-stage mode places a rising-edge register in front of the falling-edge output register, for inputs that are truly asynchronous. One-stage mode feeds the qualified value straight into the falling-edge register, which shortens the latency. A synchronous, active-high reset clears both registers.

Top module: `bus_ready_sync`

## Requirements
- R1: Source k contributes to the qualified ready only while `bus_en_n[k]` is 0. While `bus_en_n[k]` is 1, the value of `rdy_in[k]` has no effect on `ready_o`.
- R2: The qualified ready is the OR of `rdy_in[k] & ~bus_en_n[k]` over all sources. `ready_o` is 1 (active high) when any enabled source reports ready.
- R3: With `one_stage_sel` = 1, `ready_o` takes the qualified ready present at each falling clock edge.
- R4: With `one_stage_sel` = 0, the qualified ready is registered on each rising edge, and `ready_o` takes that registered value at the following falling edge.
- R5: Suppose inputs change just after rising edge k. In one-stage mode the change appears on `ready_o` after the falling edge of the same cycle. In two-stage mode it appears one clock later, after the falling edge of cycle k+1.
- R6: When `rst` is 1 at a falling edge, `ready_o` is cleared there. `ready_o` stays 0 for as long as `rst` stays 1. The rising-edge stage is also cleared, so a source that was ready before reset does not reappear afterwards.
- R7: `ready_o` comes from a register. An input change made after a falling edge does not alter `ready_o` before the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; the stages use both edges |
| rst | input | 1 | Synchronous reset, active high |
| one_stage_sel | input | 1 | Strap: 1 selects one stage, 0 selects two stages |
| rdy_in | input | N_SRC | Per-source ready, active high |
| bus_en_n | input | N_SRC | Per-source enable, active low |
| ready_o | output | 1 | Synchronized ready to the processor, active high |

## Verification
The bench uses the default of two sources. With two sources, every combination of enable and ready can be reached, including both sources ready at once and a source that is ready but disabled. The mode strap is changed between cycles in the random part of the bench, so the output register is exercised on both input paths, including the cycle just after a mode change. Directed sequences measure the one-clock latency gap between the modes. They also drive inputs that change after the falling edge, and apply a reset while a source is ready.

// File: rtl/bus_ready_pkg.sv
package bus_ready_pkg;
  typedef enum logic {
    SYNC_TWO_STAGE = 1'b0,
    SYNC_ONE_STAGE = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/ready_qualify.sv
module ready_qualify #(
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0] rdy_i,
  input  logic [N_SRC-1:0] en_n_i,
  output logic             qual_o
);
  logic [N_SRC-1:0] gated;

  // each source is gated only by its own enable
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    assign gated[k] = rdy_i[k] & ~en_n_i[k];
  end

  assign qual_o = |gated;
endmodule

// File: rtl/ready_rise_stage.sv
module ready_rise_stage (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= d_i;
  end

  // R4: first stage follows the qualified ready one rising edge later
  p_rise_capture_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> q_o == $past(d_i));
endmodule

// File: rtl/ready_fall_stage.sv
module ready_fall_stage
  import bus_ready_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sync_mode_e mode_i,
  input  logic       direct_i,
  input  logic       staged_i,
  output logic       q_o
);
  logic next_d;

  always_comb begin
    next_d = (mode_i == SYNC_ONE_STAGE) ? direct_i : staged_i;
  end

  always_ff @(negedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= next_d;
  end

  // R3: one-stage mode takes the qualified value at the falling edge
  p_one_stage_r3: assert property (@(negedge clk) disable iff (rst)
    (!rst && mode_i == SYNC_ONE_STAGE) |=> q_o == $past(direct_i));

  // R4: two-stage mode takes the rising-edge register
  p_two_stage_r4: assert property (@(negedge clk) disable iff (rst)
    (!rst && mode_i == SYNC_TWO_STAGE) |=> q_o == $past(staged_i));

  // R6: reset at a falling edge leaves the output low
  p_reset_clear_r6: assert property (@(negedge clk)
    rst |=> !q_o);
endmodule

// File: rtl/bus_ready_sync.sv
module bus_ready_sync
  import bus_ready_pkg::*;
#(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             one_stage_sel,
  input  logic [N_SRC-1:0] rdy_in,
  input  logic [N_SRC-1:0] bus_en_n,
  output logic             ready_o
);
  logic       qual;
  logic       stage1;
  sync_mode_e mode;

  assign mode = sync_mode_e'(one_stage_sel);

  ready_qualify #(.N_SRC(N_SRC)) u_qual (
    .rdy_i  (rdy_in),
    .en_n_i (bus_en_n),
    .qual_o (qual)
  );

  ready_rise_stage u_rise (
    .clk (clk),
    .rst (rst),
    .d_i (qual),
    .q_o (stage1)
  );

  ready_fall_stage u_fall (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode),
    .direct_i (qual),
    .staged_i (stage1),
    .q_o      (ready_o)
  );

  // R1: with every source disabled, no ready reaches the first stage
  p_all_disabled_r1: assert property (@(posedge clk) disable iff (rst)
    (!rst && (&bus_en_n)) |=> !stage1);
endmodule

// File: tb/bus_ready_sync_bench.sv
module bus_ready_sync_bench;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst;
  logic         one_stage_sel;
  logic [N-1:0] rdy_in;
  logic [N-1:0] bus_en_n;
  logic         ready_o;

  int vectors = 0;
  int fails   = 0;
  logic m_s1  = 1'b0;

  always #10 clk = ~clk;

  bus_ready_sync #(.N_SRC(N)) u_bus_ready_sync (
    .clk           (clk),
    .rst           (rst),
    .one_stage_sel (one_stage_sel),
    .rdy_in        (rdy_in),
    .bus_en_n      (bus_en_n),
    .ready_o       (ready_o)
  );

  function automatic logic qual_ref(input logic [N-1:0] r, input logic [N-1:0] e);
    return |(r & ~e);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s ready_o=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive just after the rising edge, check after the falling
  // edge, then optionally change the inputs again after the falling edge.
  task automatic cycle(input logic r, input logic m,
                       input logic [N-1:0] rd, input logic [N-1:0] en,
                       input bit late, input logic [N-1:0] rd2,
                       input logic [N-1:0] en2, input string tag);
    logic q, exp, hold;
    string t;
    @(posedge clk);
    #2;
    rst = r; one_stage_sel = m; rdy_in = rd; bus_en_n = en;
    q = qual_ref(rd, en);
    exp = r ? 1'b0 : (m ? q : m_s1);
    #13;
    t = tag;
    if (t == "") t = r ? "R6" : (m ? "R3" : "R4");
    check(ready_o, exp, t);
    if (late) begin
      #2;
      rdy_in = rd2; bus_en_n = en2;
      q = qual_ref(rd2, en2);
      hold = exp;
      #2;
      check(ready_o, hold, "R7");
    end
    m_s1 = r ? 1'b0 : q;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; one_stage_sel = 1'b0; rdy_in = '0; bus_en_n = '1;
    // reset state, R6
    for (int i = 0; i < 3; i++) cycle(1, 0, 2'b11, 2'b00, 0, '0, '0, "R6");

    // R1: a ready but disabled source is ignored
    for (int i = 0; i < 3; i++) cycle(0, 1, 2'b11, 2'b11, 0, '0, '0, "R1");
    cycle(0, 1, 2'b01, 2'b10, 0, '0, '0, "R1");
    cycle(0, 1, 2'b10, 2'b10, 0, '0, '0, "R1");
    cycle(0, 1, 2'b10, 2'b01, 0, '0, '0, "R1");
    // R2: either enabled source, or both, raise ready
    cycle(0, 1, 2'b01, 2'b00, 0, '0, '0, "R2");
    cycle(0, 1, 2'b10, 2'b00, 0, '0, '0, "R2");
    cycle(0, 1, 2'b11, 2'b00, 0, '0, '0, "R2");
    cycle(0, 1, 2'b00, 2'b00, 0, '0, '0, "R2");

    // R5: latency, one-stage mode
    cycle(0, 1, 2'b00, 2'b00, 0, '0, '0, "R5");
    cycle(0, 1, 2'b01, 2'b00, 0, '0, '0, "R5");   // visible in same cycle
    // R5: latency, two-stage mode
    cycle(0, 0, 2'b00, 2'b00, 0, '0, '0, "R5");
    cycle(0, 0, 2'b00, 2'b00, 0, '0, '0, "R5");
    cycle(0, 0, 2'b10, 2'b00, 0, '0, '0, "R5");   // still low this cycle
    cycle(0, 0, 2'b10, 2'b00, 0, '0, '0, "R5");   // high one clock later

    // R7: changes after the falling edge wait for the next one
    cycle(0, 1, 2'b01, 2'b00, 1, 2'b00, 2'b00, "");
    cycle(0, 1, 2'b00, 2'b00, 1, 2'b11, 2'b00, "");
    cycle(0, 0, 2'b11, 2'b00, 1, 2'b00, 2'b11, "");
    cycle(0, 0, 2'b00, 2'b11, 0, '0, '0, "");

    // R6: reset while a source is ready, then it must not reappear
    cycle(0, 0, 2'b01, 2'b00, 0, '0, '0, "");
    cycle(1, 0, 2'b01, 2'b00, 0, '0, '0, "R6");
    cycle(0, 0, 2'b00, 2'b00, 0, '0, '0, "R6");

    // random traffic with mode switches and occasional reset
    for (int i = 0; i < 2000; i++) begin
      logic r, m;
      logic [N-1:0] rd, en, rd2, en2;
      bit late;
      r    = (($urandom % 32) == 0);
      m    = (($urandom % 8) == 0) ? ~one_stage_sel : one_stage_sel;
      rd   = N'($urandom);
      en   = N'($urandom);
      late = (($urandom % 4) == 0);
      rd2  = N'($urandom);
      en2  = N'($urandom);
      cycle(r, m, rd, en, late, rd2, en2, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule